// File: doc/BRIEF.md
# Clock Synthesizer Parameter Register File

This block holds the frequency codes for two clock synthesizers: one that makes the pixel clock and one that makes the memory clock. It also decides which stored code pair each synthesizer receives. A host reaches sixteen indexed registers over an 8-bit bus. It first loads an index into an address register. It then moves bytes one at a time through a data port. The index steps forward by itself once a whole register has been moved.

Indices 0 to 7 hold eight pixel-clock code pairs. Indices 10 and 11 hold two memory-clock code pairs. Index 14 is a one-byte control register. Each of the other indices holds a low byte and a high byte.

The pixel-clock pair is chosen from one of three sources:
- the control register, under software control;
- three select pins read directly;
- two select pins captured on a strobe.

A control bit chooses the memory-clock pair. The selected codes drive the synthesizer inputs combinationally.

Top module: `pllreg_file`

## Requirements
- R1: After reset the index is 0 and the byte pointer is on the low byte. Pixel sets 0..7 hold (low/high) 7D/50, 55/49, 2A/43, 77/4A, 79/49, 6F/47, 74/2B, 71/29. Index 10 holds 5C/3E and index 11 holds 40/28. Every other byte is 00, including control. The pin latch is 0, so the outputs show set 0 and memory set 10.
- R2: A write strobe with regSel=0 loads dataIn[3:0] into the index and returns the pointer to the low byte; dataIn[7:4] is ignored. With regSel=0, dataOut shows {4'h0, index}.
- R3: For an index other than 14, the first data transfer (regSel=1) is the low byte (M code) and the second is the high byte (N code). After the second transfer the index increments.
- R4: Index 14 is one byte long. A single transfer there moves the index to 15.
- R5: Stepping past index 15 wraps the index to 0.
- R6: With regSel=1, dataOut shows the byte under the pointer. A read strobe advances exactly as a write does and changes no stored byte. If both strobes arrive in the same cycle, the write takes effect.
- R7: The control byte is laid out as follows, and bits 7:6 are stored and read back with no other effect:
  - bits 2:0: software pixel-set number;
  - bit 3: memory set;
  - bit 4: software source;
  - bit 5: direct-pin mode.
- R8: With control bit 4 = 0 and bit 5 = 1, the pixel set is selPins[2:0], used combinationally.
- R9: With bits 4 and 5 both 0, the pixel set is {0, latch}. The 2-bit latch takes selPins[1:0] on a clock edge where selStrobe is high. Pin changes without a strobe, and selPins[2], have no effect.
- R10: With control bit 4 = 1, the pixel set is control bits 2:0 and the pins are ignored.
- R11: Control bit 3 = 0 selects index 10 for memM/memN; bit 3 = 1 selects index 11.
- R12: A write to the selected set shows on vidM/vidN or memM/memN in the cycle after the write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| regSel | input | 1 | 0 selects the address register, 1 the data port |
| wrStb | input | 1 | One-cycle write strobe |
| rdStb | input | 1 | One-cycle read strobe (consumes the shown byte) |
| dataIn | input | 8 | Write data |
| dataOut | output | 8 | Index or addressed byte, combinational |
| selPins | input | 3 | External pixel-set select pins |
| selStrobe | input | 1 | Capture enable for the latched pin mode |
| vidM | output | 8 | Active pixel-clock M code |
| vidN | output | 8 | Active pixel-clock N code |
| memM | output | 8 | Active memory-clock M code |
| memN | output | 8 | Active memory-clock N code |

## Verification
The bench targets the points where this block can go wrong.

- **Byte lengths.** The one-byte control index is stepped over. A design that treated it as two bytes would stall the index at 14 and write the next byte into a phantom high byte.
- **Index wrap.** Wrapping from 15 to 0 is covered. A bad increment would land on a wrong register.
- **Reads.** Reads must advance the pointer but never corrupt data. A pointer that advanced only on writes would show the same byte twice.
- **Latched pin mode.** Pin changes without a strobe, and the unused third pin, must be ignored. A design that leaked them would switch the clock code without a strobe.

Random bus and pin traffic is compared each cycle against a behavioural model.

// File: rtl/pllreg_pkg.sv
package pllreg_pkg;
  localparam int DATA_W = 8;
  localparam int IDX_W  = 4;

  // strobes from control to datapath
  typedef struct packed {
    logic              wrEn;
    logic [IDX_W-1:0]  idx;
    logic              hi;
    logic [DATA_W-1:0] wrData;
  } pllStb_t;

  // power-up contents, {high byte, low byte}
  function automatic logic [2*DATA_W-1:0] resetWord(input int i);
    case (i)
      0:       return 16'h507D;
      1:       return 16'h4955;
      2:       return 16'h432A;
      3:       return 16'h4A77;
      4:       return 16'h4979;
      5:       return 16'h476F;
      6:       return 16'h2B74;
      7:       return 16'h2971;
      10:      return 16'h3E5C;
      11:      return 16'h2840;
      default: return 16'h0000;
    endcase
  endfunction
endpackage

// File: rtl/pllreg_ctl.sv
module pllreg_ctl
  import pllreg_pkg::*;
#(
  parameter int NUM_REG  = 16,
  parameter int CTRL_IDX = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regSel,
  input  logic              wrStb,
  input  logic              rdStb,
  input  logic [DATA_W-1:0] dataIn,
  output pllStb_t           stb,
  output logic [IDX_W-1:0]  curIdx,
  output logic              curHi
);
  localparam logic [IDX_W-1:0] CtrlIdx = IDX_W'(CTRL_IDX);
  localparam logic [IDX_W-1:0] LastIdx = IDX_W'(NUM_REG - 1);

  logic addrWr;
  logic xfer;
  logic lastByte;

  assign addrWr   = wrStb & ~regSel;
  assign xfer     = regSel & (wrStb | rdStb);
  assign lastByte = curHi | (curIdx == CtrlIdx);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curIdx <= '0;
      curHi  <= 1'b0;
    end else if (addrWr) begin
      curIdx <= dataIn[IDX_W-1:0];
      curHi  <= 1'b0;
    end else if (xfer) begin
      if (lastByte) begin
        curIdx <= (curIdx == LastIdx) ? '0 : curIdx + 1'b1;
        curHi  <= 1'b0;
      end else begin
        curHi  <= 1'b1;
      end
    end
  end

  always_comb begin
    stb.wrEn   = regSel & wrStb;
    stb.idx    = curIdx;
    stb.hi     = curHi;
    stb.wrData = dataIn;
  end
endmodule

// File: rtl/pllreg_dp.sv
module pllreg_dp
  import pllreg_pkg::*;
#(
  parameter int NUM_REG   = 16,
  parameter int CTRL_IDX  = 14,
  parameter int MEM_A_IDX = 10,
  parameter int PIN_W     = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  pllStb_t           stb,
  input  logic [PIN_W-1:0]  selPins,
  input  logic              selStrobe,
  output logic [DATA_W-1:0] rdByte,
  output logic [DATA_W-1:0] vidM,
  output logic [DATA_W-1:0] vidN,
  output logic [DATA_W-1:0] memM,
  output logic [DATA_W-1:0] memN
);
  localparam int LATCH_W = PIN_W - 1;

  logic [NUM_REG-1:0][DATA_W-1:0] loByte;
  logic [NUM_REG-1:0][DATA_W-1:0] hiByte;
  logic [LATCH_W-1:0]             pinLatch;
  logic [DATA_W-1:0]              ctrl;
  logic [PIN_W-1:0]               vidSel;
  logic [IDX_W-1:0]               vidIdx;
  logic [IDX_W-1:0]               memIdx;

  // one storage slice per index
  for (genvar g = 0; g < NUM_REG; g++) begin : g_reg
    localparam logic [2*DATA_W-1:0] Init = resetWord(g);
    always_ff @(posedge clk) begin
      if (!rstN) begin
        loByte[g] <= Init[DATA_W-1:0];
        hiByte[g] <= Init[2*DATA_W-1:DATA_W];
      end else if (stb.wrEn && stb.idx == IDX_W'(g)) begin
        if (stb.hi) hiByte[g] <= stb.wrData;
        else        loByte[g] <= stb.wrData;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)          pinLatch <= '0;
    else if (selStrobe) pinLatch <= selPins[LATCH_W-1:0];
  end

  assign ctrl = loByte[CTRL_IDX];

  // pixel-set source: software, direct pins, or latched pins
  always_comb begin
    if (ctrl[4])      vidSel = ctrl[PIN_W-1:0];
    else if (ctrl[5]) vidSel = selPins;
    else              vidSel = {1'b0, pinLatch};
  end

  assign vidIdx = IDX_W'(vidSel);
  assign memIdx = IDX_W'(MEM_A_IDX) + IDX_W'(ctrl[3]);

  assign vidM   = loByte[vidIdx];
  assign vidN   = hiByte[vidIdx];
  assign memM   = loByte[memIdx];
  assign memN   = hiByte[memIdx];
  assign rdByte = stb.hi ? hiByte[stb.idx] : loByte[stb.idx];
endmodule

// File: rtl/pllreg_file.sv
module pllreg_file
  import pllreg_pkg::*;
#(
  parameter int NUM_REG   = 16,
  parameter int CTRL_IDX  = 14,
  parameter int MEM_A_IDX = 10,
  parameter int PIN_W     = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regSel,
  input  logic              wrStb,
  input  logic              rdStb,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  input  logic [PIN_W-1:0]  selPins,
  input  logic              selStrobe,
  output logic [DATA_W-1:0] vidM,
  output logic [DATA_W-1:0] vidN,
  output logic [DATA_W-1:0] memM,
  output logic [DATA_W-1:0] memN
);
  pllStb_t           stb;
  logic [IDX_W-1:0]  curIdx;
  logic              curHi;
  logic [DATA_W-1:0] rdByte;

  pllreg_ctl #(.NUM_REG(NUM_REG), .CTRL_IDX(CTRL_IDX)) i_ctl (
    .clk(clk), .rstN(rstN), .regSel(regSel), .wrStb(wrStb), .rdStb(rdStb),
    .dataIn(dataIn), .stb(stb), .curIdx(curIdx), .curHi(curHi)
  );

  pllreg_dp #(.NUM_REG(NUM_REG), .CTRL_IDX(CTRL_IDX), .MEM_A_IDX(MEM_A_IDX),
              .PIN_W(PIN_W)) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .selPins(selPins), .selStrobe(selStrobe),
    .rdByte(rdByte), .vidM(vidM), .vidN(vidN), .memM(memM), .memN(memN)
  );

  assign dataOut = regSel ? rdByte : DATA_W'(curIdx);
endmodule

// File: rtl/pllreg_chk.sv
module pllreg_chk
  import pllreg_pkg::*;
#(
  parameter int CTRL_IDX = 14,
  parameter int PIN_W    = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              regSel,
  input logic              wrStb,
  input logic              rdStb,
  input logic [DATA_W-1:0] dataIn,
  input logic [PIN_W-1:0]  selPins,
  input logic              selStrobe,
  input logic [DATA_W-1:0] vidM,
  input logic [DATA_W-1:0] vidN,
  input logic [DATA_W-1:0] memM,
  input logic [DATA_W-1:0] memN,
  input logic [IDX_W-1:0]  curIdx,
  input logic              curHi
);
  logic xfer;
  assign xfer = regSel & (wrStb | rdStb);

  assert_addr_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrStb && !regSel) |=> (curIdx == $past(dataIn[IDX_W-1:0])) && !curHi);

  assert_low_then_high_R3: assert property (@(posedge clk) disable iff (!rstN)
    (xfer && !curHi && curIdx != IDX_W'(CTRL_IDX)) |=> curHi && $stable(curIdx));

  assert_ctrl_one_byte_R4: assert property (@(posedge clk) disable iff (!rstN)
    (xfer && curIdx == IDX_W'(CTRL_IDX)) |=> (curIdx == IDX_W'(CTRL_IDX + 1)) && !curHi);

  assert_index_wrap_R5: assert property (@(posedge clk) disable iff (!rstN)
    (xfer && curHi && curIdx == '1) |=> (curIdx == '0) && !curHi);

  assert_quiet_codes_R9: assert property (@(posedge clk) disable iff (!rstN)
    ($past(!wrStb && !selStrobe) && $stable(selPins)) |->
      $stable({vidM, vidN, memM, memN}));
endmodule

bind pllreg_file pllreg_chk #(.CTRL_IDX(CTRL_IDX), .PIN_W(PIN_W)) i_chk (
  .clk(clk), .rstN(rstN), .regSel(regSel), .wrStb(wrStb), .rdStb(rdStb),
  .dataIn(dataIn), .selPins(selPins), .selStrobe(selStrobe),
  .vidM(vidM), .vidN(vidN), .memM(memM), .memN(memN),
  .curIdx(curIdx), .curHi(curHi)
);

// File: tb/test_pllreg_file.sv
module test_pllreg_file;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regSel = 1'b0, wrStb = 1'b0, rdStb = 1'b0, selStrobe = 1'b0;
  logic [7:0] dataIn = 8'h00;
  logic [2:0] selPins = 3'd0;
  logic [7:0] dataOut, vidM, vidN, memM, memN;

  int total = 0;
  int bad   = 0;

  // reference model state
  int mLo[16];
  int mHi[16];
  int mIdx, mHiPtr, mLatch;

  always #4 clk = ~clk;

  pllreg_file i_pllreg_file (
    .clk(clk), .rstN(rstN), .regSel(regSel), .wrStb(wrStb), .rdStb(rdStb),
    .dataIn(dataIn), .dataOut(dataOut), .selPins(selPins), .selStrobe(selStrobe),
    .vidM(vidM), .vidN(vidN), .memM(memM), .memN(memN)
  );

  task automatic modelReset();
    int lo[16] = '{'h7D,'h55,'h2A,'h77,'h79,'h6F,'h74,'h71,0,0,'h5C,'h40,0,0,0,0};
    int hi[16] = '{'h50,'h49,'h43,'h4A,'h49,'h47,'h2B,'h29,0,0,'h3E,'h28,0,0,0,0};
    for (int i = 0; i < 16; i++) begin
      mLo[i] = lo[i];
      mHi[i] = hi[i];
    end
    mIdx = 0; mHiPtr = 0; mLatch = 0;
  endtask

  function automatic int expVidSet();
    int c = mLo[14];
    if (c & 'h10) return c & 7;
    if (c & 'h20) return int'(selPins);
    return mLatch;
  endfunction

  function automatic int expMemSet();
    return (mLo[14] & 8) ? 11 : 10;
  endfunction

  function automatic int expData();
    if (!regSel) return mIdx;
    return mHiPtr ? mHi[mIdx] : mLo[mIdx];
  endfunction

  always @(posedge clk) begin
    if (!rstN) modelReset();
    else begin
      if (selStrobe) mLatch = int'(selPins[1:0]);
      if (wrStb && !regSel) begin
        mIdx = int'(dataIn[3:0]); mHiPtr = 0;
      end else if (regSel && (wrStb || rdStb)) begin
        if (wrStb) begin
          if (mHiPtr) mHi[mIdx] = int'(dataIn);
          else        mLo[mIdx] = int'(dataIn);
        end
        if (mHiPtr || mIdx == 14) begin
          mIdx = (mIdx + 1) % 16; mHiPtr = 0;
        end else mHiPtr = 1;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN) begin
      chk("R12 model vidM", int'(vidM), mLo[expVidSet()]);
      chk("R12 model vidN", int'(vidN), mHi[expVidSet()]);
      chk("R11 model memM", int'(memM), mLo[expMemSet()]);
      chk("R11 model memN", int'(memN), mHi[expMemSet()]);
      chk("R6 model dataOut", int'(dataOut), expData());
    end
  end

  task automatic busOp(input logic sel, input logic wr, input logic rd, input logic [7:0] d);
    @(negedge clk); #1;
    regSel = sel; wrStb = wr; rdStb = rd; dataIn = d;
    @(negedge clk); #1;
    wrStb = 1'b0; rdStb = 1'b0;
  endtask

  task automatic strobePins(input logic [2:0] p);
    @(negedge clk); #1;
    selPins = p; selStrobe = 1'b1;
    @(negedge clk); #1;
    selStrobe = 1'b0;
  endtask

  task automatic setPins(input logic [2:0] p);
    @(negedge clk); #1;
    selPins = p;
    @(negedge clk); #1;
  endtask

  task automatic peek(input logic sel);
    regSel = sel; #1;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    bad++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rstN = 1'b1;
    #1;
    // R1 reset state
    chk("R1 vidM", vidM, 'h7D); chk("R1 vidN", vidN, 'h50);
    chk("R1 memM", memM, 'h5C); chk("R1 memN", memN, 'h3E);
    peek(0); chk("R1 index", dataOut, 0);
    peek(1); chk("R1 byte0", dataOut, 'h7D);

    // R2 address load, upper nibble ignored
    busOp(0, 1, 0, 8'hF3);
    peek(0); chk("R2 index", dataOut, 3);
    // R3 / R6 read walk
    peek(1); chk("R3 low byte", dataOut, 'h77);
    busOp(1, 0, 1, 8'h00);
    peek(1); chk("R3 high byte", dataOut, 'h4A);
    busOp(1, 0, 1, 8'h00);
    peek(0); chk("R3 next index", dataOut, 4);
    peek(1); chk("R6 read no change", dataOut, 'h79);

    // R4 / R10 control single byte, software select set 5
    busOp(0, 1, 0, 8'h0E);
    busOp(1, 1, 0, 8'h15);
    peek(0); chk("R4 index after ctrl", dataOut, 15);
    chk("R10 vidM", vidM, 'h6F); chk("R10 vidN", vidN, 'h47);
    setPins(3'd7);
    chk("R10 pins ignored", vidM, 'h6F);

    // R5 wrap
    busOp(1, 1, 0, 8'hAA);
    busOp(1, 1, 0, 8'hBB);
    peek(0); chk("R5 wrap", dataOut, 0);

    // R12 write active set
    busOp(0, 1, 0, 8'h05);
    busOp(1, 1, 0, 8'h12);
    chk("R12 vidM updated", vidM, 'h12);
    busOp(1, 1, 0, 8'h34);
    chk("R12 vidN updated", vidN, 'h34);
    busOp(0, 1, 0, 8'h05);
    peek(1); chk("R6 readback low", dataOut, 'h12);
    busOp(1, 0, 1, 8'h00);
    peek(1); chk("R6 readback high", dataOut, 'h34);

    // R6 simultaneous strobes: write wins
    busOp(0, 1, 0, 8'h09);
    busOp(1, 1, 1, 8'h66);
    busOp(0, 1, 0, 8'h09);
    peek(1); chk("R6 wr+rd", dataOut, 'h66);

    // R11 memory select
    busOp(0, 1, 0, 8'h0E);
    busOp(1, 1, 0, 8'h1D);
    chk("R11 memM B", memM, 'h40); chk("R11 memN B", memN, 'h28);

    // R8 direct pins
    busOp(0, 1, 0, 8'h0E);
    busOp(1, 1, 0, 8'h20);
    setPins(3'd6);
    chk("R8 pins 6", vidM, 'h74); chk("R8 pins 6 N", vidN, 'h2B);
    setPins(3'd7);
    chk("R8 pins 7", vidM, 'h71);

    // R9 latched pins
    busOp(0, 1, 0, 8'h0E);
    busOp(1, 1, 0, 8'h00);
    setPins(3'd3);
    chk("R9 no strobe", vidM, 'h7D);
    strobePins(3'd3);
    chk("R9 strobe 3", vidM, 'h77);
    setPins(3'd1);
    chk("R9 held", vidM, 'h77);
    strobePins(3'd6);
    chk("R9 pin2 ignored", vidM, 'h2A);

    // R7 spare control bits stored, no effect
    busOp(0, 1, 0, 8'h0E);
    busOp(1, 1, 0, 8'hC0);
    busOp(0, 1, 0, 8'h0E);
    peek(1); chk("R7 readback", dataOut, 'hC0);
    chk("R7 no effect", vidM, 'h2A);
    chk("R7 mem A", memM, 'h5C);

    // random traffic against the model
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk); #1;
      regSel    = 1'($urandom_range(0, 3) != 0);
      wrStb     = 1'($urandom_range(0, 2) == 0);
      rdStb     = 1'($urandom_range(0, 2) == 0);
      dataIn    = 8'($urandom);
      selStrobe = 1'($urandom_range(0, 4) == 0);
      selPins   = 3'($urandom);
    end
    @(negedge clk); #1;
    wrStb = 1'b0; rdStb = 1'b0; selStrobe = 1'b0;
    repeat (2) @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule